// File: doc/BRIEF.md
# Synthetic Destination-Tag Traffic Source

This block is one traffic source for a clocked multistage switching network. On every clock it makes a fresh random decision, with a programmable probability, whether to offer a packet to the network input it drives. When it offers one, it builds the destination tag one bit per network stage. Each bit comes from its own random comparison against a probability of that bit being 0. The probabilities come from one of three modes:
- **Uniform:** every bit is 0 with probability one half.
- **Weighted:** each stage takes the probability supplied for it. Equal values above one half make a hot spot at destination 0.
- **Split:** the top tag bit is fixed by whether the source number is even or odd, and the remaining bits are uniform.

The network answers with a ready flag. A packet that is refused is dropped and never offered again, because the source holds no buffer. Two saturating counters record how many packets were offered and how many were refused, so the acceptance ratio can be computed outside the block. Many instances with different seeds, rates and probabilities model sources that each have their own traffic pattern.

Probabilities are unsigned fractions of 2^P_W with one extra bit, so the legal range 0..2^P_W covers both "never" and "always" exactly. Each decision uses its own linear feedback shift register lane.

Top module: `tg_source`

## Requirements
- R1: After a synchronous reset, `pkt_valid_o` is 0, `pkt_tag_o` is 0 and both counters are 0.
- R2: A packet is offered in a cycle with probability `rate_i`/2^P_W. A value of 0 never offers a packet, and 2^P_W (256 by default) offers one every cycle.
- R3: `pkt_valid_o` and `pkt_tag_o` are registered: inputs sampled at one clock edge decide the outputs shown after that edge. The tag is all zeros whenever `pkt_valid_o` is 0.
- R4: In weighted mode (`mode_i` = 1), tag bit i is 0 with probability p_i/2^P_W. p_i is the (P_W+1)-bit field at `stage_prob_i[i*(P_W+1) +: P_W+1]`, so p_i = 2^P_W forces the bit to 0 and p_i = 0 forces it to 1.
- R5: In weighted mode, the same value above one half on every stage biases every tag bit toward 0, which concentrates traffic on destination 0.
- R6: In uniform mode (`mode_i` = 0, and also code 3), every tag bit is 0 with probability one half and `stage_prob_i` has no effect.
- R7: In split mode (`mode_i` = 2), the top tag bit equals `src_odd_i`: an even source targets the lower half of the destinations and an odd source the upper half. The other bits are uniform and `stage_prob_i` has no effect.
- R8: A refused packet (`pkt_valid_o`=1 with `net_ready_i`=0) is not held or retried. The next cycle's output is a fresh decision.
- R9: `gen_cnt_o` rises by one for each cycle with `pkt_valid_o`=1, and `drop_cnt_o` rises by one for each such cycle with `net_ready_i`=0. Both are visible one edge later, and both stop when `gen_cnt_o` reaches its all-ones maximum.
- R10: Each tag bit and the offer decision use separate random draws, so the tag bits vary independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | 0 uniform, 1 weighted, 2 split, 3 uniform |
| rate_i | input | P_W+1 | Offer probability in units of 2^-P_W |
| stage_prob_i | input | STAGES*(P_W+1) | Per-bit probability of a 0, field i for tag bit i |
| src_odd_i | input | 1 | Lowest bit of this source's number |
| net_ready_i | input | 1 | Network accepts the offered packet this cycle |
| pkt_valid_o | output | 1 | A packet is offered |
| pkt_tag_o | output | STAGES | Destination tag, MSB used by the first stage |
| gen_cnt_o | output | CNT_W | Packets offered, saturating |
| drop_cnt_o | output | CNT_W | Packets refused, saturating |

## Verification
The bench drives each input set on a falling edge. The valid flag and tag that result are due at the next falling edge, one register away. The counters are due one edge after that. For statistical vectors, the bench skips one cycle after reset so that the outputs reflect the new settings. It then samples valid and tag on each of 256 falling edges. It reads the counters at the first and the last of these edges, so the change in each counter covers exactly the sampled cycles. The directed tests check, on exact edges, the cycle-by-cycle latency, a refusal that is not repeated, the bit positions of the weighted fields, and counter saturation.

// File: rtl/tg_pkg.sv
package tg_pkg;
  typedef enum logic [1:0] {
    TG_UNIFORM  = 2'd0,
    TG_WEIGHTED = 2'd1,
    TG_SPLIT    = 2'd2,
    TG_UNIFORM2 = 2'd3
  } tg_mode_e;
endpackage

// File: rtl/tg_rng_lane.sv
module tg_rng_lane #(
  parameter int LFSR_W = 16,
  parameter int P_W = 8,
  parameter logic [LFSR_W-1:0] TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] SEED = 16'h0001
) (
  input  logic           clk,
  input  logic           rst,
  output logic [P_W-1:0] rnd_o
);
  localparam logic [LFSR_W-1:0] INIT = (SEED == '0) ? LFSR_W'(1) : SEED;

  logic [LFSR_W-1:0] state;

  // P_W Galois steps per clock so each draw is built from fresh bits
  function automatic logic [LFSR_W-1:0] advance(input logic [LFSR_W-1:0] s);
    logic [LFSR_W-1:0] t;
    t = s;
    for (int k = 0; k < P_W; k++) begin
      t = t[0] ? ((t >> 1) ^ TAPS) : (t >> 1);
    end
    return t;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) state <= INIT;
    else     state <= advance(state);
  end

  assign rnd_o = state[P_W-1:0];

  // R10
  lfsr_live_chk: assert property (@(posedge clk) disable iff (rst) state != '0)
    else $error("random lane stuck at zero");
endmodule

// File: rtl/tg_tag_builder.sv
module tg_tag_builder import tg_pkg::*; #(
  parameter int STAGES = 4,
  parameter int P_W = 8
) (
  input  tg_mode_e                        mode_i,
  input  logic                            src_odd_i,
  input  logic [STAGES*(P_W+1)-1:0]       stage_prob_i,
  input  logic [STAGES-1:0][P_W-1:0]      rnd_i,
  output logic [STAGES-1:0]               tag_o
);
  localparam int PF_W = P_W + 1;
  localparam logic [PF_W-1:0] HALF = {2'b01, {(P_W-1){1'b0}}};

  for (genvar i = 0; i < STAGES; i++) begin : g_bit
    logic [PF_W-1:0] p_eff;
    logic            draw_one;
    always_comb begin
      p_eff = (mode_i == TG_WEIGHTED) ? stage_prob_i[i*PF_W +: PF_W] : HALF;
    end
    // bit is 0 when the draw falls below the probability of a 0
    assign draw_one = !({1'b0, rnd_i[i]} < p_eff);
    if (i == STAGES - 1) begin : g_top
      assign tag_o[i] = (mode_i == TG_SPLIT) ? src_odd_i : draw_one;
    end else begin : g_low
      assign tag_o[i] = draw_one;
    end
  end
endmodule

// File: rtl/tg_tally.sv
module tg_tally #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             offer_i,
  input  logic             ready_i,
  output logic [CNT_W-1:0] gen_o,
  output logic [CNT_W-1:0] drop_o
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      gen_o  <= '0;
      drop_o <= '0;
    end else if (offer_i && gen_o != CMAX) begin
      gen_o <= gen_o + 1'b1;
      if (!ready_i) drop_o <= drop_o + 1'b1;
    end
  end

  // R9
  drop_le_gen_chk: assert property (@(posedge clk) disable iff (rst) drop_o <= gen_o)
    else $error("refused count above offered count");
  // R9
  gen_step_chk: assert property (@(posedge clk) disable iff (rst)
      (offer_i && gen_o != CMAX) |=> gen_o == $past(gen_o) + 1'b1)
    else $error("offered count did not advance");
  // R9
  gen_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !offer_i |=> $stable(gen_o) && $stable(drop_o))
    else $error("counters moved without an offer");
  // R9
  drop_ready_chk: assert property (@(posedge clk) disable iff (rst)
      ready_i |=> $stable(drop_o))
    else $error("refused count moved on an accepted cycle");
endmodule

// File: rtl/tg_source.sv
module tg_source import tg_pkg::*; #(
  parameter int STAGES = 4,
  parameter int P_W = 8,
  parameter int CNT_W = 16,
  parameter int LFSR_W = 16,
  parameter int unsigned SEED = 32'h0000_1D2C
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [1:0]                  mode_i,
  input  logic [P_W:0]                rate_i,
  input  logic [STAGES*(P_W+1)-1:0]   stage_prob_i,
  input  logic                        src_odd_i,
  input  logic                        net_ready_i,
  output logic                        pkt_valid_o,
  output logic [STAGES-1:0]           pkt_tag_o,
  output logic [CNT_W-1:0]            gen_cnt_o,
  output logic [CNT_W-1:0]            drop_cnt_o
);
  localparam int LANES = STAGES + 1;
  localparam int PF_W = P_W + 1;
  localparam logic [PF_W-1:0] FULL = {1'b1, {P_W{1'b0}}};

  tg_mode_e                   mode;
  logic [LANES-1:0][P_W-1:0]  rnd;
  logic [STAGES-1:0][P_W-1:0] tag_rnd;
  logic [STAGES-1:0]          tag_next;
  logic                       emit;

  assign mode = tg_mode_e'(mode_i);

  // lane 0 decides the offer, lane i+1 draws tag bit i
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    tg_rng_lane #(
      .LFSR_W(LFSR_W),
      .P_W   (P_W),
      .SEED  (LFSR_W'(SEED + 32'(g + 1) * 32'd40503))
    ) u_lane (
      .clk  (clk),
      .rst  (rst),
      .rnd_o(rnd[g])
    );
  end

  for (genvar g = 0; g < STAGES; g++) begin : g_route
    assign tag_rnd[g] = rnd[g+1];
  end

  assign emit = {1'b0, rnd[0]} < rate_i;

  tg_tag_builder #(
    .STAGES(STAGES),
    .P_W   (P_W)
  ) u_build (
    .mode_i      (mode),
    .src_odd_i   (src_odd_i),
    .stage_prob_i(stage_prob_i),
    .rnd_i       (tag_rnd),
    .tag_o       (tag_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pkt_valid_o <= 1'b0;
      pkt_tag_o   <= '0;
    end else begin
      pkt_valid_o <= emit;
      pkt_tag_o   <= emit ? tag_next : '0;
    end
  end

  tg_tally #(.CNT_W(CNT_W)) u_tally (
    .clk    (clk),
    .rst    (rst),
    .offer_i(pkt_valid_o),
    .ready_i(net_ready_i),
    .gen_o  (gen_cnt_o),
    .drop_o (drop_cnt_o)
  );

  // R2
  idle_rate_chk: assert property (@(posedge clk) disable iff (rst)
      rate_i == '0 |=> !pkt_valid_o)
    else $error("offer with zero rate");
  // R2
  full_rate_chk: assert property (@(posedge clk) disable iff (rst)
      rate_i == FULL |=> pkt_valid_o)
    else $error("no offer with full rate");
  // R3
  idle_tag_chk: assert property (@(posedge clk) disable iff (rst)
      !pkt_valid_o |-> pkt_tag_o == '0)
    else $error("tag not cleared while idle");
  // R7
  split_top_chk: assert property (@(posedge clk) disable iff (rst)
      mode_i == 2'd2 |=> (!pkt_valid_o || pkt_tag_o[STAGES-1] == $past(src_odd_i)))
    else $error("split mode top bit does not follow source parity");

  for (genvar i = 0; i < STAGES; i++) begin : g_wchk
    // R4
    wfull_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'd1 && stage_prob_i[i*PF_W +: PF_W] == FULL) |=> !pkt_tag_o[i])
      else $error("weighted bit not forced to zero");
    // R4
    wnull_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'd1 && stage_prob_i[i*PF_W +: PF_W] == '0) |=>
          (!pkt_valid_o || pkt_tag_o[i]))
      else $error("weighted bit not forced to one");
  end
endmodule

// File: tb/tg_source_tb_top.sv
`timescale 1ns/1ps
module tg_source_tb_top;
  localparam int STAGES = 4;
  localparam int P_W = 8;
  localparam int CNT_W = 10;
  localparam int WIN = 256;

  typedef struct packed {
    logic [1:0] mode;
    logic [8:0] rate;
    logic [8:0] prob;
    logic       odd;
    logic       ready;
    logic [9:0] vmin;
    logic [9:0] vmax;
    logic [7:0] zlo;
    logic [7:0] zhi;
    logic [1:0] top;   // 0 no check, 1 top bit must be 0, 2 must be 1
    logic       indep;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 9'd256, 9'd256, 1'b0, 1'b1, 10'd256, 10'd256, 8'd30,  8'd70,  2'd0, 1'b1},
    '{2'd0, 9'd0,   9'd128, 1'b0, 1'b1, 10'd0,   10'd0,   8'd0,   8'd100, 2'd0, 1'b0},
    '{2'd0, 9'd128, 9'd128, 1'b0, 1'b1, 10'd96,  10'd160, 8'd30,  8'd70,  2'd0, 1'b1},
    '{2'd1, 9'd256, 9'd256, 1'b0, 1'b1, 10'd256, 10'd256, 8'd100, 8'd100, 2'd0, 1'b0},
    '{2'd1, 9'd256, 9'd0,   1'b0, 1'b1, 10'd256, 10'd256, 8'd0,   8'd0,   2'd0, 1'b0},
    '{2'd1, 9'd256, 9'd192, 1'b0, 1'b1, 10'd256, 10'd256, 8'd60,  8'd90,  2'd0, 1'b0},
    '{2'd2, 9'd256, 9'd256, 1'b0, 1'b0, 10'd256, 10'd256, 8'd30,  8'd70,  2'd1, 1'b0},
    '{2'd2, 9'd256, 9'd0,   1'b1, 1'b1, 10'd256, 10'd256, 8'd30,  8'd70,  2'd2, 1'b0},
    '{2'd1, 9'd64,  9'd64,  1'b0, 1'b0, 10'd36,  10'd92,  8'd8,   8'd42,  2'd0, 1'b0},
    '{2'd3, 9'd256, 9'd0,   1'b0, 1'b1, 10'd256, 10'd256, 8'd30,  8'd70,  2'd0, 1'b1}
  };

  logic                        clk = 1'b0;
  logic                        rst = 1'b1;
  logic [1:0]                  mode_i = 2'd0;
  logic [P_W:0]                rate_i = '0;
  logic [STAGES*(P_W+1)-1:0]   stage_prob_i = '0;
  logic                        src_odd_i = 1'b0;
  logic                        net_ready_i = 1'b1;
  logic                        pkt_valid_o;
  logic [STAGES-1:0]           pkt_tag_o;
  logic [CNT_W-1:0]            gen_cnt_o;
  logic [CNT_W-1:0]            drop_cnt_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tg_source #(.STAGES(STAGES), .P_W(P_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .mode_i(mode_i), .rate_i(rate_i),
    .stage_prob_i(stage_prob_i), .src_odd_i(src_odd_i), .net_ready_i(net_ready_i),
    .pkt_valid_o(pkt_valid_o), .pkt_tag_o(pkt_tag_o),
    .gen_cnt_o(gen_cnt_o), .drop_cnt_o(drop_cnt_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [STAGES*(P_W+1)-1:0] all_prob(input logic [P_W:0] p);
    return {STAGES{p}};
  endfunction

  function automatic string tag_req(input vec_t v);
    if (v.mode == 2'd1 && v.prob > 9'd128 && v.prob < 9'd256) return "R5";
    if (v.mode == 2'd1) return "R4";
    if (v.mode == 2'd2) return "R7";
    return "R6";
  endfunction

  // reset with settings held, then one cycle so outputs reflect them
  task automatic restart();
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    rst = 1'b0;
    rate_i = '0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(pkt_valid_o == 1'b0, "R1", "valid after reset", pkt_valid_o, 0);
    check(pkt_tag_o == '0, "R1", "tag after reset", pkt_tag_o, 0);
    check(gen_cnt_o == '0 && drop_cnt_o == '0, "R1", "counters after reset",
          gen_cnt_o + drop_cnt_o, 0);

    // statistical vectors
    for (int vi = 0; vi < NV; vi++) begin
      vec_t v;
      int vcount;
      int eqcount;
      int zeros [STAGES];
      int g0, d0;
      int nbits;
      v = VECS[vi];
      mode_i = v.mode;
      rate_i = v.rate;
      stage_prob_i = all_prob(v.prob);
      src_odd_i = v.odd;
      net_ready_i = v.ready;
      restart();
      g0 = gen_cnt_o;
      d0 = drop_cnt_o;
      vcount = 0;
      eqcount = 0;
      for (int b = 0; b < STAGES; b++) zeros[b] = 0;
      for (int c = 0; c < WIN; c++) begin
        if (pkt_valid_o) begin
          vcount++;
          if (pkt_tag_o == '0 || pkt_tag_o == '1) eqcount++;
          for (int b = 0; b < STAGES; b++) if (!pkt_tag_o[b]) zeros[b]++;
          if (v.top == 2'd1)
            check(pkt_tag_o[STAGES-1] == 1'b0, "R7", "even source top bit", pkt_tag_o[STAGES-1], 0);
          if (v.top == 2'd2)
            check(pkt_tag_o[STAGES-1] == 1'b1, "R7", "odd source top bit", pkt_tag_o[STAGES-1], 1);
        end
        @(negedge clk);
      end
      check(vcount >= int'(v.vmin) && vcount <= int'(v.vmax), "R2", "offers in window",
            vcount, int'(v.vmin));
      check(int'(gen_cnt_o) - g0 == vcount, "R9", "offered count delta",
            int'(gen_cnt_o) - g0, vcount);
      check(int'(drop_cnt_o) - d0 == (v.ready ? 0 : vcount), "R9", "refused count delta",
            int'(drop_cnt_o) - d0, v.ready ? 0 : vcount);
      nbits = (v.top != 2'd0) ? STAGES - 1 : STAGES;
      if (vcount > 0) begin
        for (int b = 0; b < nbits; b++) begin
          check(zeros[b] * 100 >= int'(v.zlo) * vcount && zeros[b] * 100 <= int'(v.zhi) * vcount,
                tag_req(v), $sformatf("zero share of bit %0d (percent)", b),
                zeros[b] * 100 / vcount, int'(v.zlo));
        end
        if (v.indep)
          check(eqcount * 100 < 40 * vcount, "R10", "tags with all bits equal",
                eqcount, vcount * 2 / 16);
      end
    end

    // R4 field positions: bits 3 and 1 forced to 1, bits 2 and 0 forced to 0
    mode_i = 2'd1;
    rate_i = 9'd256;
    net_ready_i = 1'b1;
    stage_prob_i = {9'd0, 9'd256, 9'd0, 9'd256};
    restart();
    for (int c = 0; c < 8; c++) begin
      check(pkt_valid_o && pkt_tag_o == 4'b1010, "R4", "per-stage field tag", pkt_tag_o, 4'b1010);
      @(negedge clk);
    end

    // R3 latency, R8 no retry, R9 counter timing
    rate_i = '0;
    stage_prob_i = all_prob(9'd256);
    restart();
    rate_i = 9'd256;
    #0.5;
    check(pkt_valid_o == 1'b0, "R3", "no offer before an edge", pkt_valid_o, 0);
    @(negedge clk);
    check(pkt_valid_o == 1'b1 && pkt_tag_o == '0, "R3", "offer one edge after rate", pkt_valid_o, 1);
    check(gen_cnt_o == '0, "R9", "offer not yet counted", gen_cnt_o, 0);
    rate_i = '0;
    net_ready_i = 1'b0;
    @(negedge clk);
    check(pkt_valid_o == 1'b0, "R8", "refused packet not offered again", pkt_valid_o, 0);
    check(pkt_tag_o == '0, "R3", "tag cleared when idle", pkt_tag_o, 0);
    check(gen_cnt_o == 10'd1, "R9", "offered count", gen_cnt_o, 1);
    check(drop_cnt_o == 10'd1, "R9", "refused count", drop_cnt_o, 1);
    @(negedge clk);
    check(gen_cnt_o == 10'd1 && drop_cnt_o == 10'd1, "R9", "counters hold when idle",
          gen_cnt_o, 1);

    // R9 saturation
    rate_i = 9'd256;
    net_ready_i = 1'b0;
    restart();
    repeat (1100) @(negedge clk);
    check(gen_cnt_o == '1, "R9", "offered count saturates", gen_cnt_o, 1023);
    check(drop_cnt_o == '1, "R9", "refused count saturates", drop_cnt_o, 1023);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule